// File: doc/BRIEF.md
# Dimension-Ordered Wormhole Mesh Router

This block is one router tile of a two-dimensional mesh. It has five ports: four 32-bit links to the neighbouring tiles (north, south, east, west) and one port to the processor of its own tile. Traffic moves as variable-length packets. A header word comes first and carries the destination column, the destination row and the number of payload words that follow it. A packet holds at most 32 words in total.

Each incoming word is captured in a register stage and then stored in a per-input FIFO. The link inputs hold four words each. The injection path from the processor holds sixteen. The router compares the header's destination with its own column first and corrects X. Only when the column matches does it correct Y, and a packet addressed to this tile is handed to the local port. An output is claimed by one packet from the header to the last word, so packets never interleave on a link. When several headers want the same free output, round-robin arbitration picks one. Every port uses valid/ready flow control, and a full buffer stalls the sender instead of losing data.

Each output has a small output FIFO. The link outputs hold two words each. The delivery path to the processor holds four.

Top module: `mesh_router`

## Requirements
- R1: Port index 0 is north, 1 is south, 2 is east, 3 is west and 4 is local. The header carries destination x in bits [31:28] and destination y in bits [27:24]. When destination x is greater than the router's own x, the packet leaves east. When it is smaller, the packet leaves west, whatever the y values are.
- R2: When destination x equals the router's x, a destination y greater than the router's y goes north and a smaller one goes south.
- R3: A header whose x and y both equal the router's position is delivered on the local port.
- R4: Header bits [4:0] give the number of payload words that follow the header (0 to 31). The header and exactly that many following words leave on the chosen output, in order and unchanged.
- R5: Once a header has been granted an output, no word from any other input appears on that output until the granted packet's last word has passed.
- R6: When headers from several inputs compete for a free output, they are granted round-robin. No input receives a second grant while another competing input is still waiting.
- R7: When a link output is stalled, a path from a link input to that output absorbs exactly 6 words: 4 in the input buffer and 2 in the output stage. After that, the input's ready stays low.
- R8: When a link output is stalled, the path from the local injection port to that output absorbs exactly 18 words: 16 in the injection buffer and 2 in the output stage.
- R9: When the local output is stalled, a path from a link input to it absorbs exactly 8 words: 4 in the input buffer and 4 on the delivery path.
- R10: No accepted word is ever lost. While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R11: While reset is high, every out_valid is low. Every in_ready is high from the second clock after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 5 | Per-port incoming word valid (index 0 N, 1 S, 2 E, 3 W, 4 local) |
| in_data | input | 5x32 | Per-port incoming word |
| in_ready | output | 5 | Per-port ready to the sender, registered |
| out_valid | output | 5 | Per-port outgoing word valid |
| out_data | output | 5x32 | Per-port outgoing word |
| out_ready | input | 5 | Per-port ready from the receiver |

## Verification
The assertions check three properties on every cycle. An output that stays locked keeps the same owner. No input feeds two outputs at once. A stalled output neither drops nor alters the word it is presenting. The directed scenarios check the rest: the X-before-Y route choice, the exact number of words delivered for zero, mid-range and maximum lengths, the absence of interleaving when two inputs contend, and the fairness of round-robin among three inputs. The scenarios also measure the exact storage of each path type when an output is stalled, and this count is the only evidence that the 4, 16 and 4 word buffer depths are in place.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;

  localparam int NPORT = 5;

  typedef enum logic [2:0] {
    PORT_N = 3'd0,
    PORT_S = 3'd1,
    PORT_E = 3'd2,
    PORT_W = 3'd3,
    PORT_L = 3'd4
  } port_e;

  // Dimension-ordered choice: settle the column first, then the row.
  function automatic logic [2:0] route_dir(input logic [7:0] dst_x, input logic [7:0] dst_y,
                                           input logic [7:0] own_x, input logic [7:0] own_y);
    if (dst_x > own_x)      return PORT_E;
    else if (dst_x < own_x) return PORT_W;
    else if (dst_y > own_y) return PORT_N;
    else if (dst_y < own_y) return PORT_S;
    else                    return PORT_L;
  endfunction

endpackage

// File: rtl/sync_fifo.sv
module sync_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic [$clog2(DEPTH):0] fill
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  // Storage without reset so it maps onto RAM resources.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
      fill <= fill + (AW+1)'(wr_en) - (AW+1)'(rd_en);
    end
  end

  assign rd_data = mem[rptr];
  assign empty   = (fill == '0);
endmodule

// File: rtl/mr_in_port.sv
module mr_in_port #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lnk_valid,
  input  logic [DW-1:0] lnk_data,
  output logic          lnk_ready,
  output logic          head_valid,
  output logic [DW-1:0] head_data,
  input  logic          pop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 2;

  logic          stg_valid;
  logic [DW-1:0] stg_data;
  logic          ready_q;
  logic          empty;
  logic [AW:0]   fill;
  logic [CW-1:0] fill_next;
  logic          take;

  assign take      = lnk_valid & ready_q;
  assign fill_next = CW'(fill) + CW'(stg_valid) - CW'(pop);

  // Link register stage: nothing sits in front of it.
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_valid <= 1'b0;
      ready_q   <= 1'b0;
    end else begin
      stg_valid <= take;
      // Room must remain for the word in flight plus one more.
      ready_q   <= (fill_next + CW'(take)) <= CW'(DEPTH - 1);
    end
  end

  always_ff @(posedge clk) begin
    stg_data <= lnk_data;
  end

  sync_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (stg_valid),
    .wr_data (stg_data),
    .rd_en   (pop),
    .rd_data (head_data),
    .empty   (empty),
    .fill    (fill)
  );

  assign lnk_ready  = ready_q;
  assign head_valid = ~empty;
endmodule

// File: rtl/mr_out_ctrl.sv
module mr_out_ctrl #(
  parameter int NPORT = 5,
  parameter int LEN_W = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NPORT-1:0]                req,
  input  logic [NPORT-1:0][LEN_W-1:0]     lens,
  input  logic [NPORT-1:0]                src_valid,
  input  logic                            sink_full,
  output logic                            locked,
  output logic [$clog2(NPORT)-1:0]        owner,
  output logic                            xfer
);
  localparam int PW = $clog2(NPORT);
  localparam int RW = LEN_W + 1;

  logic [PW-1:0] rr_ptr;
  logic [PW-1:0] gnt_idx;
  logic          gnt_any;
  logic [RW-1:0] rem;

  // Round-robin search starting just after the last winner.
  always_comb begin
    int idx;
    gnt_any = 1'b0;
    gnt_idx = rr_ptr;
    for (int k = 1; k <= NPORT; k++) begin
      idx = (int'(rr_ptr) + k) % NPORT;
      if (!gnt_any && req[idx]) begin
        gnt_any = 1'b1;
        gnt_idx = PW'(idx);
      end
    end
  end

  assign xfer = locked & src_valid[owner] & ~sink_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      owner  <= '0;
      rem    <= '0;
      rr_ptr <= PW'(NPORT - 1);
    end else if (!locked) begin
      if (gnt_any) begin
        locked <= 1'b1;
        owner  <= gnt_idx;
        rem    <= RW'(lens[gnt_idx]) + RW'(1);
        rr_ptr <= gnt_idx;
      end
    end else if (xfer) begin
      rem <= rem - RW'(1);
      if (rem == RW'(1)) locked <= 1'b0;
    end
  end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mesh_router_pkg::*;
#(
  parameter int DATA_W          = 32,
  parameter int COORD_W         = 4,
  parameter int LEN_W           = 5,
  parameter int MY_X            = 2,
  parameter int MY_Y            = 2,
  parameter int LINK_IN_DEPTH   = 4,
  parameter int LOCAL_IN_DEPTH  = 16,
  parameter int LINK_OUT_DEPTH  = 2,
  parameter int LOCAL_OUT_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NPORT-1:0]              in_valid,
  input  logic [NPORT-1:0][DATA_W-1:0]  in_data,
  output logic [NPORT-1:0]              in_ready,
  output logic [NPORT-1:0]              out_valid,
  output logic [NPORT-1:0][DATA_W-1:0]  out_data,
  input  logic [NPORT-1:0]              out_ready
);
  localparam int PW    = $clog2(NPORT);
  localparam int XMSB  = DATA_W - 1;
  localparam int YMSB  = DATA_W - 1 - COORD_W;

  logic [NPORT-1:0]              head_valid;
  logic [NPORT-1:0][DATA_W-1:0]  head_data;
  logic [NPORT-1:0]              pop;
  logic [NPORT-1:0]              busy;
  logic [NPORT-1:0][NPORT-1:0]   req;
  logic [NPORT-1:0][LEN_W-1:0]   lens;
  logic [NPORT-1:0]              locked;
  logic [NPORT-1:0][PW-1:0]      owner;
  logic [NPORT-1:0]              xfer;
  logic [NPORT-1:0]              out_full;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    localparam int DEP = (i == int'(PORT_L)) ? LOCAL_IN_DEPTH : LINK_IN_DEPTH;
    mr_in_port #(.DW(DATA_W), .DEPTH(DEP)) u_in (
      .clk        (clk),
      .rst        (rst),
      .lnk_valid  (in_valid[i]),
      .lnk_data   (in_data[i]),
      .lnk_ready  (in_ready[i]),
      .head_valid (head_valid[i]),
      .head_data  (head_data[i]),
      .pop        (pop[i])
    );
    assign lens[i] = head_data[i][LEN_W-1:0];
  end

  // An input is busy while any output is locked to it.
  always_comb begin
    busy = '0;
    pop  = '0;
    for (int o = 0; o < NPORT; o++) begin
      if (locked[o]) busy[owner[o]] = 1'b1;
      if (xfer[o])   pop[owner[o]]  = 1'b1;
    end
  end

  always_comb begin
    logic [2:0] dir;
    req = '0;
    for (int i = 0; i < NPORT; i++) begin
      dir = route_dir(8'(head_data[i][XMSB -: COORD_W]), 8'(head_data[i][YMSB -: COORD_W]),
                      8'(MY_X), 8'(MY_Y));
      for (int o = 0; o < NPORT; o++) begin
        req[o][i] = head_valid[i] & ~busy[i] & (dir == 3'(o));
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    localparam int DEP = (o == int'(PORT_L)) ? LOCAL_OUT_DEPTH : LINK_OUT_DEPTH;
    logic                  empty;
    logic [$clog2(DEP):0]  fill;

    mr_out_ctrl #(.NPORT(NPORT), .LEN_W(LEN_W)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .req       (req[o]),
      .lens      (lens),
      .src_valid (head_valid),
      .sink_full (out_full[o]),
      .locked    (locked[o]),
      .owner     (owner[o]),
      .xfer      (xfer[o])
    );

    sync_fifo #(.DW(DATA_W), .DEPTH(DEP)) u_ofifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (xfer[o]),
      .wr_data (head_data[owner[o]]),
      .rd_en   (out_valid[o] & out_ready[o]),
      .rd_data (out_data[o]),
      .empty   (empty),
      .fill    (fill)
    );

    assign out_full[o]  = (fill == ($clog2(DEP)+1)'(DEP));
    assign out_valid[o] = ~empty;
  end
endmodule

// File: rtl/mesh_router_chk.sv
module mesh_router_chk #(
  parameter int NPORT  = 5,
  parameter int PW     = 3,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NPORT-1:0]              locked,
  input logic [NPORT-1:0][PW-1:0]      owner,
  input logic [NPORT-1:0]              xfer,
  input logic [NPORT-1:0]              out_valid,
  input logic [NPORT-1:0]              out_ready,
  input logic [NPORT-1:0][DATA_W-1:0]  out_data
);
  logic [NPORT-1:0][NPORT-1:0] use_v;

  always_comb begin
    for (int i = 0; i < NPORT; i++)
      for (int o = 0; o < NPORT; o++)
        use_v[i][o] = xfer[o] && (owner[o] == PW'(i));
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    // R5: a lock that persists keeps the same owner
    assert_lock_hold_R5: assert property (@(posedge clk) disable iff (rst)
      locked[o] |=> (!locked[o] || $stable(owner[o])));
    // R10: a stalled output keeps its word
    assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_data[o])));
    // R10: valid only drops after a handshake
    assert_out_nodrop_R10: assert property (@(posedge clk) disable iff (rst)
      $fell(out_valid[o]) |-> $past(out_ready[o]));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    // R5: one input never feeds two outputs in the same cycle
    assert_single_path_R5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(use_v[i]));
  end
endmodule

bind mesh_router mesh_router_chk #(.NPORT(NPORT), .PW(PW), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .locked    (locked),
  .owner     (owner),
  .xfer      (xfer),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_mesh_router.sv
module test_mesh_router;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [NP-1:0]         in_valid  = '0;
  logic [NP-1:0][31:0]   in_data   = '0;
  logic [NP-1:0]         in_ready;
  logic [NP-1:0]         out_valid;
  logic [NP-1:0][31:0]   out_data;
  logic [NP-1:0]         out_ready = '1;

  int tests = 0;
  int fails = 0;
  int accepted [NP];
  logic [31:0] rxq [NP][$];

  mesh_router #(.MY_X(2), .MY_Y(2)) i_mesh_router (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  // Record handshakes just before each rising edge.
  always begin
    @(negedge clk); #4;
    for (int p = 0; p < NP; p++)
      if (out_valid[p] && out_ready[p]) rxq[p].push_back(out_data[p]);
  end

  function automatic logic [31:0] hdr(input int x, input int y, input int len);
    return {4'(x), 4'(y), 19'd0, 5'(len)};
  endfunction

  function automatic logic [31:0] pl(input int tag, input int seq);
    return {8'hA5, 8'(tag), 16'(seq)};
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input int p, input logic [31:0] w);
    in_data[p]  = w;
    in_valid[p] = 1'b1;
    while (!in_ready[p]) @(negedge clk);
    @(negedge clk);
    accepted[p]++;
    in_valid[p] = 1'b0;
  endtask

  task automatic send_pkt(input int p, input int x, input int y, input int len, input int tag);
    push(p, hdr(x, y, len));
    for (int k = 0; k < len; k++) push(p, pl(tag, k));
  endtask

  task automatic clear_rx();
    for (int p = 0; p < NP; p++) begin
      rxq[p].delete();
      accepted[p] = 0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pkt(input int o, input int base, input int x, input int y,
                            input int len, input int tag, input string req);
    bit ok = (rxq[o].size() >= base + len + 1);
    chk(ok, {req, " size"}, 32'(rxq[o].size()), 32'(base + len + 1));
    if (ok) begin
      bit same = (rxq[o][base] == hdr(x, y, len));
      for (int k = 0; k < len; k++) same &= (rxq[o][base+1+k] == pl(tag, k));
      chk(same, {req, " words"}, rxq[o][base], hdr(x, y, len));
    end
  endtask

  task automatic t_reset();
    idle(4);
    chk(out_valid == '0, "R11 out_valid in reset", 32'(out_valid), 32'h0);
    rst = 1'b0;
    idle(3);
    chk(in_ready == '1, "R11 in_ready after reset", 32'(in_ready), 32'h1f);
  endtask

  task automatic route_case(input int src, input int x, input int y, input int exp_o, input string req);
    int others = 0;
    clear_rx();
    send_pkt(src, x, y, 0, 0);
    idle(30);
    for (int p = 0; p < NP; p++) if (p != exp_o) others += rxq[p].size();
    expect_pkt(exp_o, 0, x, y, 0, 0, req);
    chk(others == 0, {req, " stray words"}, 32'(others), 32'h0);
  endtask

  task automatic t_route();
    route_case(4, 3, 2, 2, "R1 east");
    route_case(4, 1, 2, 3, "R1 west");
    route_case(0, 3, 3, 2, "R1 x before y (east)");
    route_case(1, 0, 0, 3, "R1 x before y (west)");
    route_case(4, 2, 3, 0, "R2 north");
    route_case(3, 2, 1, 1, "R2 south");
    route_case(0, 2, 2, 4, "R3 local");
  endtask

  task automatic t_length();
    clear_rx();
    send_pkt(0, 3, 2, 5, 1);
    idle(30);
    expect_pkt(2, 0, 3, 2, 5, 1, "R4 len5");
    clear_rx();
    send_pkt(3, 2, 0, 31, 2);
    idle(60);
    expect_pkt(1, 0, 2, 0, 31, 2, "R4 len31");
  endtask

  task automatic t_lock();
    logic [7:0] ta, tb;
    bit ok = 1'b1;
    clear_rx();
    fork
      send_pkt(0, 3, 2, 6, 8'h11);
      send_pkt(1, 3, 2, 6, 8'h22);
    join
    idle(40);
    chk(rxq[2].size() == 14, "R5 total words", 32'(rxq[2].size()), 32'd14);
    if (rxq[2].size() == 14) begin
      ta = rxq[2][1][23:16];
      tb = rxq[2][8][23:16];
      for (int k = 1; k < 7; k++) ok &= (rxq[2][k][23:16] == ta) && (rxq[2][k+7][23:16] == tb);
      ok &= (ta != tb) && (rxq[2][0] == hdr(3, 2, 6)) && (rxq[2][7] == hdr(3, 2, 6));
      chk(ok, "R5 no interleave", {24'd0, ta}, {24'd0, tb});
    end
  endtask

  task automatic t_rr();
    logic [7:0] t [6];
    clear_rx();
    fork
      begin send_pkt(0, 2, 2, 1, 1); send_pkt(0, 2, 2, 1, 1); end
      begin send_pkt(1, 2, 2, 1, 2); send_pkt(1, 2, 2, 1, 2); end
      begin send_pkt(3, 2, 2, 1, 3); send_pkt(3, 2, 2, 1, 3); end
    join
    idle(60);
    chk(rxq[4].size() == 12, "R6 total words", 32'(rxq[4].size()), 32'd12);
    if (rxq[4].size() == 12) begin
      for (int k = 0; k < 6; k++) t[k] = rxq[4][2*k+1][23:16];
      chk(t[0] != t[1] && t[1] != t[2] && t[0] != t[2], "R6 first round distinct",
          {8'd0, t[0], t[1], t[2]}, 32'h0);
      chk(t[3] != t[4] && t[4] != t[5] && t[3] != t[5], "R6 second round distinct",
          {8'd0, t[3], t[4], t[5]}, 32'h0);
    end
  endtask

  task automatic depth_case(input int src, input int x, input int y, input int o,
                            input int len, input int exp_cnt, input string req);
    clear_rx();
    out_ready[o] = 1'b0;
    fork
      send_pkt(src, x, y, len, 7);
      begin
        idle(60);
        chk(accepted[src] == exp_cnt, {req, " absorbed"}, 32'(accepted[src]), 32'(exp_cnt));
        chk(rxq[o].size() == 0, "R10 nothing leaves while stalled", 32'(rxq[o].size()), 32'h0);
        out_ready[o] = 1'b1;
      end
    join
    idle(60);
    expect_pkt(o, 0, x, y, len, 7, "R10 all delivered after stall");
  endtask

  task automatic t_depth();
    depth_case(3, 3, 2, 2, 11, 6, "R7 link path");
    depth_case(4, 3, 2, 2, 23, 18, "R8 injection path");
    depth_case(0, 2, 2, 4, 11, 8, "R9 delivery path");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_route();
    t_length();
    t_lock();
    t_rr();
    t_depth();
    summary();
    $finish;
  end
endmodule